// File: doc/BRIEF.md
# Wide Slot-Word Expander

This stage takes one narrow operation per cycle and widens it into a microword with eight fixed execution slots: two integer slots, a logic slot, a shift slot, a floating-point slot, two memory ports and a condition slot. The operation is placed into the slot that matches its unit class, and every other slot carries the all-zero NOP field. One opcode is a fused add-and-subtract pair that fills both integer slots in the same word.

The operation arrives with an opcode and four register fields. The result is registered, so the word, its valid flag and an illegal-opcode flag appear one clock after the input. Fetch, operand reads and execution belong to the neighbouring stages. A downstream scheduler uses the fixed slot order to steer each field to its unit.

Top module: `uop_slot_expander`

## Requirements
- R1: Slot s of `out_word` occupies bits [s*SLOT_W +: SLOT_W]. The slot order is: 0 first integer, 1 second integer, 2 logic, 3 shift, 4 floating point, 5 memory port 1, 6 memory port 2, 7 condition. Each slot field is {uop, rd, ra, rb}, most significant first. A NOP slot is all zeros.
- R2: `out_valid` is `in_valid` delayed by one clock. The word and the flag that belong to an input appear in that same cycle.
- R3: Opcode 0x01 (add) puts {1, rd, ra, rb} in slot 0, and opcode 0x02 (subtract) puts {2, rd, ra, rb} in slot 0. All other slots are NOP, and `in_rc` has no effect.
- R4: Opcode 0x03 (fused pair) puts {1, rd, ra, rb} in slot 0 and {2, rc, ra, rb} in slot 1. The other six slots are NOP.
- R5: The bitwise opcodes 0x04, 0x05 and 0x06 go to slot 2 with uop 1, 2 and 3 (and, or, xor).
- R6: The shift opcodes 0x08, 0x09, 0x0A and 0x0B go to slot 3 with uop 1, 2, 3 and 4 (shift left, shift right, rotate right, rotate left).
- R7: The floating-point opcodes 0x0C and 0x0D go to slot 4 with uop 1 and 2 (add, multiply).
- R8: Opcodes 0x10 and 0x12 go to slot 5, and opcodes 0x11 and 0x13 go to slot 6. Loads (0x10, 0x11) use uop 1 and stores (0x12, 0x13) use uop 2.
- R9: The compare-branch opcodes 0x14 and 0x15 go to slot 7 with uop 1 and 2 (branch if equal, branch if not equal).
- R10: Opcode 0x00 yields an all-NOP word with `out_illegal` low. Every other opcode not listed yields an all-NOP word with `out_illegal` high.
- R11: In the cycle after `in_valid` is low, `out_valid` and `out_illegal` are low and `out_word` is all zeros, whatever the other inputs hold.
- R12: While `rst` is high, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operation present |
| in_op | input | OP_W | Opcode |
| in_rd | input | REG_W | Destination register |
| in_ra | input | REG_W | First source register |
| in_rb | input | REG_W | Second source register |
| in_rc | input | REG_W | Destination for the second half of the fused pair |
| out_valid | output | 1 | Output word present |
| out_word | output | 8*SLOT_W | Eight-slot microword |
| out_illegal | output | 1 | Opcode was undefined |

## Verification
The hardest case to reach is the fused pair. It is the only input that fills two slots, and its second half takes its destination from `in_rc`, which every other opcode ignores. The stimulus sends the fused opcode back to back with plain adds that carry a nonzero `in_rc`. This shows that the second integer slot fills only for the pair, and that no field is left over into the next word. Undefined opcodes are placed between valid ones and carry random register fields, so an all-NOP result cannot simply come from zero inputs.

// File: rtl/slotx_pkg.sv
package slotx_pkg;
   localparam int NSLOTS  = 8;
   localparam int SL_INT0 = 0;
   localparam int SL_INT1 = 1;
   localparam int SL_LOG  = 2;
   localparam int SL_SHF  = 3;
   localparam int SL_FP   = 4;
   localparam int SL_MEM1 = 5;
   localparam int SL_MEM2 = 6;
   localparam int SL_CND  = 7;

   localparam int OPC_NOP  = 'h00;
   localparam int OPC_ADD  = 'h01;
   localparam int OPC_SUB  = 'h02;
   localparam int OPC_ADSB = 'h03;
   localparam int OPC_AND  = 'h04;
   localparam int OPC_OR   = 'h05;
   localparam int OPC_XOR  = 'h06;
   localparam int OPC_SHL  = 'h08;
   localparam int OPC_SHR  = 'h09;
   localparam int OPC_ROR  = 'h0A;
   localparam int OPC_ROL  = 'h0B;
   localparam int OPC_FADD = 'h0C;
   localparam int OPC_FMUL = 'h0D;
   localparam int OPC_LD1  = 'h10;
   localparam int OPC_LD2  = 'h11;
   localparam int OPC_ST1  = 'h12;
   localparam int OPC_ST2  = 'h13;
   localparam int OPC_BEQ  = 'h14;
   localparam int OPC_BNE  = 'h15;

   localparam int U_ADD = 1;
   localparam int U_SUB = 2;
endpackage

// File: rtl/slotx_decode.sv
module slotx_decode
   import slotx_pkg::*;
#(
   parameter int OP_W    = 6,
   parameter int UOP_W   = 4,
   parameter bit FUSE_EN = 1'b1
) (
   input  logic [OP_W-1:0]   op,
   output logic [NSLOTS-1:0] hit,
   output logic [UOP_W-1:0]  uop,
   output logic              fused,
   output logic              illegal
);
   logic fuse_ok;

   generate
      if (FUSE_EN) begin : g_fuse
         assign fuse_ok = 1'b1;
      end else begin : g_nofuse
         assign fuse_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      hit     = '0;
      uop     = '0;
      fused   = 1'b0;
      illegal = 1'b0;
      case (op)
         OP_W'(OPC_NOP):  ;
         OP_W'(OPC_ADD):  begin hit[SL_INT0] = 1'b1; uop = UOP_W'(U_ADD); end
         OP_W'(OPC_SUB):  begin hit[SL_INT0] = 1'b1; uop = UOP_W'(U_SUB); end
         OP_W'(OPC_ADSB): begin
            if (fuse_ok) begin
               hit[SL_INT0] = 1'b1;
               hit[SL_INT1] = 1'b1;
               uop          = UOP_W'(U_ADD);
               fused        = 1'b1;
            end else begin
               illegal = 1'b1;
            end
         end
         OP_W'(OPC_AND):  begin hit[SL_LOG]  = 1'b1; uop = UOP_W'(1); end
         OP_W'(OPC_OR):   begin hit[SL_LOG]  = 1'b1; uop = UOP_W'(2); end
         OP_W'(OPC_XOR):  begin hit[SL_LOG]  = 1'b1; uop = UOP_W'(3); end
         OP_W'(OPC_SHL):  begin hit[SL_SHF]  = 1'b1; uop = UOP_W'(1); end
         OP_W'(OPC_SHR):  begin hit[SL_SHF]  = 1'b1; uop = UOP_W'(2); end
         OP_W'(OPC_ROR):  begin hit[SL_SHF]  = 1'b1; uop = UOP_W'(3); end
         OP_W'(OPC_ROL):  begin hit[SL_SHF]  = 1'b1; uop = UOP_W'(4); end
         OP_W'(OPC_FADD): begin hit[SL_FP]   = 1'b1; uop = UOP_W'(1); end
         OP_W'(OPC_FMUL): begin hit[SL_FP]   = 1'b1; uop = UOP_W'(2); end
         OP_W'(OPC_LD1):  begin hit[SL_MEM1] = 1'b1; uop = UOP_W'(1); end
         OP_W'(OPC_LD2):  begin hit[SL_MEM2] = 1'b1; uop = UOP_W'(1); end
         OP_W'(OPC_ST1):  begin hit[SL_MEM1] = 1'b1; uop = UOP_W'(2); end
         OP_W'(OPC_ST2):  begin hit[SL_MEM2] = 1'b1; uop = UOP_W'(2); end
         OP_W'(OPC_BEQ):  begin hit[SL_CND]  = 1'b1; uop = UOP_W'(1); end
         OP_W'(OPC_BNE):  begin hit[SL_CND]  = 1'b1; uop = UOP_W'(2); end
         default:         illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/slotx_build.sv
module slotx_build
   import slotx_pkg::*;
#(
   parameter int REG_W  = 5,
   parameter int UOP_W  = 4,
   localparam int SLOT_W = UOP_W + 3*REG_W,
   localparam int WORD_W = NSLOTS*SLOT_W
) (
   input  logic [NSLOTS-1:0] hit,
   input  logic [UOP_W-1:0]  uop,
   input  logic              fused,
   input  logic [REG_W-1:0]  rd,
   input  logic [REG_W-1:0]  ra,
   input  logic [REG_W-1:0]  rb,
   input  logic [REG_W-1:0]  rc,
   output logic [WORD_W-1:0] word
);
   logic [SLOT_W-1:0] prim_f;
   logic [SLOT_W-1:0] pair_f;

   assign prim_f = {uop, rd, ra, rb};
   assign pair_f = {UOP_W'(U_SUB), rc, ra, rb};

   genvar s;
   generate
      for (s = 0; s < NSLOTS; s++) begin : g_slot
         if (s == SL_INT1) begin : g_pair
            assign word[s*SLOT_W +: SLOT_W] =
               hit[s] ? (fused ? pair_f : prim_f) : '0;
         end else begin : g_plain
            assign word[s*SLOT_W +: SLOT_W] = hit[s] ? prim_f : '0;
         end
      end
   endgenerate
endmodule

// File: rtl/slotx_out_stage.sv
module slotx_out_stage #(
   parameter int WORD_W = 152
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              d_valid,
   input  logic [WORD_W-1:0] d_word,
   input  logic              d_illegal,
   output logic              q_valid,
   output logic [WORD_W-1:0] q_word,
   output logic              q_illegal
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q_valid   <= 1'b0;
         q_word    <= '0;
         q_illegal <= 1'b0;
      end else if (d_valid) begin
         q_valid   <= 1'b1;
         q_word    <= d_word;
         q_illegal <= d_illegal;
      end else begin
         q_valid   <= 1'b0;
         q_word    <= '0;
         q_illegal <= 1'b0;
      end
   end

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
      d_valid |=> q_valid);
   a_r11_idle_clear: assert property (@(posedge clk) disable iff (rst)
      !d_valid |=> (!q_valid && !q_illegal && q_word == '0));
endmodule

// File: rtl/uop_slot_expander.sv
module uop_slot_expander
   import slotx_pkg::*;
#(
   parameter int OP_W    = 6,
   parameter int REG_W   = 5,
   parameter int UOP_W   = 4,
   parameter bit FUSE_EN = 1'b1,
   localparam int SLOT_W = UOP_W + 3*REG_W,
   localparam int WORD_W = NSLOTS*SLOT_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   in_op,
   input  logic [REG_W-1:0]  in_rd,
   input  logic [REG_W-1:0]  in_ra,
   input  logic [REG_W-1:0]  in_rb,
   input  logic [REG_W-1:0]  in_rc,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word,
   output logic              out_illegal
);
   generate
      if (OP_W < 5) begin : g_chk_op
         $error("OP_W must hold opcodes up to 0x15");
      end
      if (UOP_W < 3) begin : g_chk_uop
         $error("UOP_W must hold unit codes up to 4");
      end
      if (REG_W < 1) begin : g_chk_reg
         $error("REG_W must be positive");
      end
   endgenerate

   logic [NSLOTS-1:0] dec_hit;
   logic [UOP_W-1:0]  dec_uop;
   logic              dec_fused;
   logic              dec_illegal;
   logic [WORD_W-1:0] wide_d;

   slotx_decode #(.OP_W(OP_W), .UOP_W(UOP_W), .FUSE_EN(FUSE_EN)) u_dec (
      .op(in_op), .hit(dec_hit), .uop(dec_uop),
      .fused(dec_fused), .illegal(dec_illegal)
   );

   slotx_build #(.REG_W(REG_W), .UOP_W(UOP_W)) u_bld (
      .hit(dec_hit), .uop(dec_uop), .fused(dec_fused),
      .rd(in_rd), .ra(in_ra), .rb(in_rb), .rc(in_rc), .word(wide_d)
   );

   slotx_out_stage #(.WORD_W(WORD_W)) u_out (
      .clk(clk), .rst(rst),
      .d_valid(in_valid), .d_word(wide_d), .d_illegal(dec_illegal),
      .q_valid(out_valid), .q_word(out_word), .q_illegal(out_illegal)
   );

   logic [NSLOTS-1:0] busy;
   genvar b;
   generate
      for (b = 0; b < NSLOTS; b++) begin : g_busy
         assign busy[b] = |out_word[b*SLOT_W +: SLOT_W];
      end
   endgenerate

   always_comb begin
      if (!rst && dec_illegal) begin
         a_r10_decode_empty: assert (wide_d == '0);
      end
   end

   a_r10_illegal_empty: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> (out_valid && out_word == '0));
   a_r3_at_most_two: assert property (@(posedge clk) disable iff (rst)
      $countones(busy) <= 2);
   a_r4_pair_shape: assert property (@(posedge clk) disable iff (rst)
      busy[SL_INT1] |-> (busy[SL_INT0] && $countones(busy) == 2 &&
         out_word[SL_INT1*SLOT_W + SLOT_W - 1 -: UOP_W] == UOP_W'(U_SUB)));
endmodule

// File: tb/sim_uop_slot_expander.sv
`timescale 1ns/1ps
module sim_uop_slot_expander;
   localparam int OPW = 6;
   localparam int RW  = 5;
   localparam int UW  = 4;
   localparam int SW  = UW + 3*RW;
   localparam int WW  = 8*SW;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [OPW-1:0] in_op = '0;
   logic [RW-1:0]  in_rd = '0, in_ra = '0, in_rb = '0, in_rc = '0;
   logic out_valid;
   logic [WW-1:0] out_word;
   logic out_illegal;

   int n_chk = 0;
   int n_bad = 0;

   logic [WW-1:0] q_w[$];
   logic          q_i[$];
   string         q_t[$];

   always #2 clk = ~clk;

   uop_slot_expander u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
      .in_rd(in_rd), .in_ra(in_ra), .in_rb(in_rb), .in_rc(in_rc),
      .out_valid(out_valid), .out_word(out_word), .out_illegal(out_illegal)
   );

   function automatic void model(input logic [OPW-1:0] op,
                                 input logic [RW-1:0] rd, ra, rb, rc,
                                 output logic [WW-1:0] w, output logic ill);
      int s = -1;
      int u = 0;
      w = '0; ill = 1'b0;
      case (op)
         6'h00: ;
         6'h01: begin s = 0; u = 1; end
         6'h02: begin s = 0; u = 2; end
         6'h03: begin
            w[0*SW +: SW] = {4'd1, rd, ra, rb};
            w[1*SW +: SW] = {4'd2, rc, ra, rb};
         end
         6'h04: begin s = 2; u = 1; end
         6'h05: begin s = 2; u = 2; end
         6'h06: begin s = 2; u = 3; end
         6'h08: begin s = 3; u = 1; end
         6'h09: begin s = 3; u = 2; end
         6'h0A: begin s = 3; u = 3; end
         6'h0B: begin s = 3; u = 4; end
         6'h0C: begin s = 4; u = 1; end
         6'h0D: begin s = 4; u = 2; end
         6'h10: begin s = 5; u = 1; end
         6'h11: begin s = 6; u = 1; end
         6'h12: begin s = 5; u = 2; end
         6'h13: begin s = 6; u = 2; end
         6'h14: begin s = 7; u = 1; end
         6'h15: begin s = 7; u = 2; end
         default: ill = 1'b1;
      endcase
      if (s >= 0) w[s*SW +: SW] = {UW'(u), rd, ra, rb};
   endfunction

   task automatic send(input logic [OPW-1:0] op, input string tag);
      logic [WW-1:0] w;
      logic il;
      logic [RW-1:0] rd = RW'($urandom), ra = RW'($urandom);
      logic [RW-1:0] rb = RW'($urandom), rc = RW'($urandom) | 1;
      @(negedge clk);
      in_valid = 1'b1; in_op = op;
      in_rd = rd; in_ra = ra; in_rb = rb; in_rc = rc;
      model(op, rd, ra, rb, rc, w, il);
      q_w.push_back(w); q_i.push_back(il); q_t.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_op = 6'h01;
         in_rd = RW'($urandom); in_ra = RW'($urandom);
         in_rb = RW'($urandom); in_rc = RW'($urandom);
      end
   endtask

   // scoreboard monitor
   initial begin
      wait (rst == 1'b0);
      forever begin
         @(posedge clk);
         #1;
         n_chk++;
         if (out_valid) begin
            if (q_w.size() == 0) begin
               n_bad++;
               $display("FAIL R2: unexpected valid word=%h exp none", out_word);
            end else begin
               logic [WW-1:0] ew;
               logic ei;
               string t;
               ew = q_w.pop_front(); ei = q_i.pop_front(); t = q_t.pop_front();
               if (out_word !== ew || out_illegal !== ei) begin
                  n_bad++;
                  $display("FAIL %s: word=%h ill=%b exp word=%h ill=%b",
                           t, out_word, out_illegal, ew, ei);
               end
            end
         end else if (out_word !== '0 || out_illegal !== 1'b0) begin
            n_bad++;
            $display("FAIL R11: idle word=%h ill=%b exp word=0 ill=0",
                     out_word, out_illegal);
         end
      end
   end

   // watchdog
   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: run did not end, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0 || out_word !== '0 || out_illegal !== 1'b0) begin
         n_bad++;
         $display("FAIL R12: reset v=%b w=%h i=%b exp all zero",
                  out_valid, out_word, out_illegal);
      end
      rst = 1'b0;
      idle(2);
      send(6'h01, "R3 add");
      send(6'h02, "R3 sub");
      send(6'h03, "R4 fused");
      send(6'h01, "R3 add after pair, rc ignored");
      send(6'h03, "R4 fused again");
      send(6'h03, "R4 fused back to back");
      idle(1);
      send(6'h04, "R5 and");
      send(6'h05, "R5 or");
      send(6'h06, "R5 xor");
      send(6'h08, "R6 shl");
      send(6'h09, "R6 shr");
      send(6'h0A, "R6 ror");
      send(6'h0B, "R6 rol");
      send(6'h0C, "R7 fadd");
      send(6'h0D, "R7 fmul");
      send(6'h10, "R8 load port1");
      send(6'h11, "R8 load port2");
      send(6'h12, "R8 store port1");
      send(6'h13, "R8 store port2");
      send(6'h14, "R9 beq");
      send(6'h15, "R9 bne");
      send(6'h00, "R10 explicit nop");
      send(6'h07, "R10 undefined 07");
      send(6'h01, "R1 add after illegal");
      send(6'h0E, "R10 undefined 0E");
      send(6'h16, "R10 undefined 16");
      send(6'h3F, "R10 undefined 3F");
      idle(3);
      for (int r = 0; r < 200; r++) begin
         logic [OPW-1:0] op = OPW'($urandom_range(0, 23));
         send(op, "R1 random mix");
         if (r % 17 == 0) idle(1);
      end
      idle(4);
      n_chk++;
      if (q_w.size() != 0) begin
         n_bad++;
         $display("FAIL R2: %0d words never produced, exp 0", q_w.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule